// File: doc/BRIEF.md
# Five-port I2C hub repeater

This block joins five I2C segments into one logical bus. Each segment's SDA and SCL pads are open-drain: the block samples each line through an input pin and pulls it low through an active-low drive output, while pull-ups hold the line high. When a device on one enabled segment pulls a line low, the block pulls the same line low on every other enabled segment without inverting it. SDA and SCL are handled by two identical channels, and each channel works on its own. Port 0 is always on the bus. Ports 1 to 4 each have an active-high enable. Enable changes take effect only when the bus is idle.

Each channel latches which ports are real sources of a low. A source is a port whose line is low while the hub is not pulling it. The hub never pulls a source port itself, so it can never hold itself low. When the last source releases, the hub keeps its driven ports low for a short hold window, then releases them. It then ignores port lows for a settle window. A port that is still low after the settle window is taken as a new source. This is how a slave's ACK and a slave's clock stretching are repeated back to the master.

Four wired-AND expansion lines let several hubs act as one larger hub. Per signal there are two of them. The "any" line is low whenever the hub is pulling any port of that signal low. The "held" line is low only while a local external source exists. A "held" low seen from another hub is treated like a source arriving on a port. Every input passes through a two-flop synchronizer and a glitch filter before the channel logic sees it.

Channel states:
- IDLE: nothing is driven.
- DRIVE: sources or a remote source are present, and all other enabled ports are driven low.
- HOLD: the last source has released, and all enabled ports stay driven for `HOLD_CYC` clocks.
- SETTLE: all drives are released, and lows are ignored for `SETTLE_CYC` clocks.

Channel transitions:
- IDLE→DRIVE: an enabled port reads low, or the held line reads low.
- DRIVE→HOLD: no source and no remote source remain.
- HOLD→SETTLE: the hold count has expired.
- SETTLE→IDLE: the settle count has expired.

Enable states:
- STEADY: the applied enables match the requested ones.
- WAIT: a change is pending.

Enable transitions:
- STEADY→WAIT: the request changes while the bus is busy.
- WAIT→STEADY: the bus becomes idle, and the latest request is applied.

Top module: `i2c_hub_top`

## Requirements
- R1: After reset every drive output is high (released), all four ports 1 to 4 are enabled, and both channels are idle.
- R2: When an external device pulls an enabled port's line low, the hub drives the same line low on every other enabled port (bit i of each port vector is port i). It never drives the source port itself. SDA and SCL are independent.
- R3: A port whose enable is low (enable bit k gates port k+1) has its SDA and SCL inputs ignored, and its drive outputs stay high.
- R4: A held expansion output is low only while a local external source exists. An any expansion output is low whenever the channel drives ports (DRIVE or HOLD). A held line is never low while the matching any output is released.
- R5: After the last source releases, all enabled ports of that signal stay driven low for HOLD_CYC clocks. They are then released together with the any expansion output.
- R6: For SETTLE_CYC clocks after release, port lows are ignored. A port still low after that window becomes a new source, so a slave ACK or clock stretch is repeated to the master.
- R7: A low on the held expansion line that this hub is not driving is a remote source. It makes the hub drive all its enabled ports of that signal low.
- R8: A change of the enable inputs is applied only when the bus is idle: both channels in IDLE, all enabled port lines high and both any expansion lines high. Until then the previous enables stay in force.
- R9: An input low pulse shorter than FILT_LEN clocks after synchronization is not propagated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en_req | input | NPORT-1 | Requested enables; bit k enables port k+1 |
| sda_in | input | NPORT | Sampled SDA line of each port |
| scl_in | input | NPORT | Sampled SCL line of each port |
| sda_pull_n | output | NPORT | Active-low SDA drive per port |
| scl_pull_n | output | NPORT | Active-low SCL drive per port |
| xsda_any_in | input | 1 | Sampled SDA any expansion line |
| xsda_held_in | input | 1 | Sampled SDA held expansion line |
| xscl_any_in | input | 1 | Sampled SCL any expansion line |
| xscl_held_in | input | 1 | Sampled SCL held expansion line |
| xsda_any_pull_n | output | 1 | Active-low drive of SDA any line |
| xsda_held_pull_n | output | 1 | Active-low drive of SDA held line |
| xscl_any_pull_n | output | 1 | Active-low drive of SCL any line |
| xscl_held_pull_n | output | 1 | Active-low drive of SCL held line |

## Verification
Two functions can fall in the same cycle. The release of the hold window on the master port can coincide with a second port, the acknowledging or stretching slave, still reading low. The bench provokes this by having the slave pull its line while the hub is already driving it, and only then releasing the master. It judges the result by requiring the master's line to be driven low again once the settle window ends. The same clash between an enable request and a busy bus is provoked by changing an enable mid-transfer. The bench then checks that the old enable still holds until the bus is idle.

// File: rtl/i2c_hub_pkg.sv
`timescale 1ns/1ps
package i2c_hub_pkg;
    typedef enum logic [1:0] {
        CH_IDLE,
        CH_DRIVE,
        CH_HOLD,
        CH_SETTLE
    } ch_state_t;

    typedef enum logic {
        EN_STEADY,
        EN_WAIT
    } en_state_t;
endpackage

// File: rtl/i2c_hub_infilt.sv
`timescale 1ns/1ps
module i2c_hub_infilt #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic          meta_q;
    logic          sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clean <= 1'b1;
            run_q <= '0;
        end else if (sync_q == clean) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            clean <= sync_q;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R9
    filt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean) |-> ($past(run_q) == LAST && $past(sync_q) != $past(clean)));
endmodule

// File: rtl/i2c_hub_engate.sv
`timescale 1ns/1ps
module i2c_hub_engate
    import i2c_hub_pkg::*;
#(
    parameter int NPORT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-2:0] en_req,
    input  logic             bus_idle,
    output logic [NPORT-1:0] en_act
);
    en_state_t        st_q, st_d;
    logic [NPORT-2:0] act_q;
    logic             apply;

    always_comb begin
        st_d  = st_q;
        apply = 1'b0;
        unique case (st_q)
            EN_STEADY: begin
                if (en_req != act_q) begin
                    if (bus_idle) apply = 1'b1;
                    else          st_d  = EN_WAIT;
                end
            end
            EN_WAIT: begin
                if (bus_idle) begin
                    apply = 1'b1;
                    st_d  = EN_STEADY;
                end
            end
            default: st_d = EN_STEADY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EN_STEADY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     act_q <= '1;
        else if (apply) act_q <= en_req;
    end

    assign en_act = {act_q, 1'b1};

    // R8
    en_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_q) |-> $past(bus_idle));
endmodule

// File: rtl/i2c_hub_chan.sv
`timescale 1ns/1ps
module i2c_hub_chan
    import i2c_hub_pkg::*;
#(
    parameter int NPORT      = 5,
    parameter int HOLD_CYC   = 4,
    parameter int SETTLE_CYC = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] ena,
    input  logic [NPORT-1:0] pin,
    input  logic             held_in,
    output logic [NPORT-1:0] drv,
    output logic             any_drv,
    output logic             held_drv,
    output logic             quiet
);
    localparam int CMAX = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);

    ch_state_t        st_q, st_d;
    logic [CW-1:0]    cnt_q;
    logic [NPORT-1:0] src_q;
    logic             rem_q;
    logic [NPORT-1:0] new_src;
    logic [NPORT-1:0] src_keep;
    logic             rem_keep;

    assign new_src  = ~pin & ena;
    assign src_keep = src_q & ~pin;
    assign rem_keep = rem_q & ~held_in;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE:   if ((|new_src) || !held_in)             st_d = CH_DRIVE;
            CH_DRIVE:  if ((src_keep == '0) && !rem_keep)      st_d = CH_HOLD;
            CH_HOLD:   if (cnt_q == HOLD_LAST)                 st_d = CH_SETTLE;
            CH_SETTLE: if (cnt_q == SETTLE_LAST)               st_d = CH_IDLE;
            default:                                           st_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CH_IDLE;
            cnt_q <= '0;
            src_q <= '0;
            rem_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q) cnt_q <= '0;
            else if (st_q == CH_HOLD || st_q == CH_SETTLE) cnt_q <= cnt_q + 1'b1;
            unique case (st_q)
                CH_IDLE: begin
                    src_q <= new_src;
                    rem_q <= ~held_in;
                end
                CH_DRIVE: begin
                    src_q <= src_keep;
                    rem_q <= rem_keep;
                end
                default: begin
                    src_q <= '0;
                    rem_q <= 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        drv      = '0;
        any_drv  = 1'b0;
        held_drv = 1'b0;
        unique case (st_q)
            CH_DRIVE: begin
                drv      = ena & ~src_q;
                any_drv  = 1'b1;
                held_drv = |src_q;
            end
            CH_HOLD: begin
                drv     = ena;
                any_drv = 1'b1;
            end
            default: ;
        endcase
    end

    assign quiet = (st_q == CH_IDLE);

    // R3
    dis_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv & ~ena) == '0);
    // R4
    held_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held_drv |-> any_drv);
    // R5
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_drv) |-> ($past(st_q) == CH_HOLD && $past(cnt_q) == HOLD_LAST));
endmodule

// File: rtl/i2c_hub_top.sv
`timescale 1ns/1ps
module i2c_hub_top #(
    parameter int NPORT      = 5,
    parameter int FILT_LEN   = 3,
    parameter int HOLD_CYC   = 4,
    parameter int SETTLE_CYC = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-2:0] port_en_req,
    input  logic [NPORT-1:0] sda_in,
    input  logic [NPORT-1:0] scl_in,
    output logic [NPORT-1:0] sda_pull_n,
    output logic [NPORT-1:0] scl_pull_n,
    input  logic             xsda_any_in,
    input  logic             xsda_held_in,
    input  logic             xscl_any_in,
    input  logic             xscl_held_in,
    output logic             xsda_any_pull_n,
    output logic             xsda_held_pull_n,
    output logic             xscl_any_pull_n,
    output logic             xscl_held_pull_n
);
    localparam int NRAW = 2 * NPORT + 4;
    localparam int NCH  = 2;

    logic [NRAW-1:0]  raw_all;
    logic [NRAW-1:0]  flt_all;
    logic [NPORT-1:0] en_act;
    logic [NPORT-1:0] pin_g  [NCH];
    logic [NPORT-1:0] drv_c  [NCH];
    logic             held_f [NCH];
    logic             any_c  [NCH];
    logic             held_c [NCH];
    logic             quiet_c[NCH];
    logic             bus_idle;

    assign raw_all = {xscl_held_in, xscl_any_in, xsda_held_in, xsda_any_in, scl_in, sda_in};

    for (genvar g = 0; g < NRAW; g++) begin : g_filt
        i2c_hub_infilt #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_all[g]),
            .clean (flt_all[g])
        );
    end

    assign pin_g[0]  = flt_all[NPORT-1:0]       | ~en_act;
    assign pin_g[1]  = flt_all[2*NPORT-1:NPORT] | ~en_act;
    assign held_f[0] = flt_all[2*NPORT+1];
    assign held_f[1] = flt_all[2*NPORT+3];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        i2c_hub_chan #(
            .NPORT      (NPORT),
            .HOLD_CYC   (HOLD_CYC),
            .SETTLE_CYC (SETTLE_CYC)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ena      (en_act),
            .pin      (pin_g[c]),
            .held_in  (held_f[c]),
            .drv      (drv_c[c]),
            .any_drv  (any_c[c]),
            .held_drv (held_c[c]),
            .quiet    (quiet_c[c])
        );
    end

    assign bus_idle = quiet_c[0] && quiet_c[1] && (&pin_g[0]) && (&pin_g[1])
                      && flt_all[2*NPORT] && flt_all[2*NPORT+2];

    i2c_hub_engate #(.NPORT(NPORT)) u_engate (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_req   (port_en_req),
        .bus_idle (bus_idle),
        .en_act   (en_act)
    );

    assign sda_pull_n       = ~drv_c[0];
    assign scl_pull_n       = ~drv_c[1];
    assign xsda_any_pull_n  = ~any_c[0];
    assign xsda_held_pull_n = ~held_c[0];
    assign xscl_any_pull_n  = ~any_c[1];
    assign xscl_held_pull_n = ~held_c[1];
endmodule

// File: tb/i2c_hub_top_tb.sv
`timescale 1ns/1ps
module i2c_hub_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [3:0] en1 = 4'hF;
    logic [4:0] d1_sda = '0, d1_scl = '0, d2_sda = '0, d2_scl = '0;
    logic [4:0] h1_sda_pn, h1_scl_pn, h2_sda_pn, h2_scl_pn;
    logic h1_xsa, h1_xsh, h1_xca, h1_xch, h2_xsa, h2_xsh, h2_xca, h2_xch;
    logic [4:0] sda1, scl1, sda2, scl2;
    logic xsa, xsh, xca, xch;

    assign sda1 = ~d1_sda & h1_sda_pn;
    assign scl1 = ~d1_scl & h1_scl_pn;
    assign sda2 = ~d2_sda & h2_sda_pn;
    assign scl2 = ~d2_scl & h2_scl_pn;
    assign xsa  = h1_xsa & h2_xsa;
    assign xsh  = h1_xsh & h2_xsh;
    assign xca  = h1_xca & h2_xca;
    assign xch  = h1_xch & h2_xch;

    i2c_hub_top u_dut (
        .clk(clk), .rst_n(rst_n), .port_en_req(en1),
        .sda_in(sda1), .scl_in(scl1), .sda_pull_n(h1_sda_pn), .scl_pull_n(h1_scl_pn),
        .xsda_any_in(xsa), .xsda_held_in(xsh), .xscl_any_in(xca), .xscl_held_in(xch),
        .xsda_any_pull_n(h1_xsa), .xsda_held_pull_n(h1_xsh),
        .xscl_any_pull_n(h1_xca), .xscl_held_pull_n(h1_xch)
    );

    i2c_hub_top u_hub2 (
        .clk(clk), .rst_n(rst_n), .port_en_req(4'hF),
        .sda_in(sda2), .scl_in(scl2), .sda_pull_n(h2_sda_pn), .scl_pull_n(h2_scl_pn),
        .xsda_any_in(xsa), .xsda_held_in(xsh), .xscl_any_in(xca), .xscl_held_in(xch),
        .xsda_any_pull_n(h2_xsa), .xsda_held_pull_n(h2_xsh),
        .xscl_any_pull_n(h2_xca), .xscl_held_pull_n(h2_xch)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // fields: en[23:20] sda pulls[19:15] scl pulls[14:10] exp sda[9:5] exp scl[4:0]
    localparam logic [23:0] VEC [6] = '{
        {4'hF,    5'b00001, 5'b00000, 5'b00000, 5'b11111},
        {4'hF,    5'b00000, 5'b01000, 5'b11111, 5'b00000},
        {4'hF,    5'b10001, 5'b00010, 5'b00000, 5'b00000},
        {4'b1011, 5'b01000, 5'b00000, 5'b10111, 5'b11111},
        {4'b1011, 5'b00100, 5'b00000, 5'b01000, 5'b11111},
        {4'b0000, 5'b00001, 5'b10000, 5'b11110, 5'b01111}
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(3);
        // R1 reset state
        chk("R1 drives released", {h1_sda_pn, h1_scl_pn, h1_xsa, h1_xsh, h1_xca, h1_xch},
            {5'h1F, 5'h1F, 4'hF});

        // R2 / R3 table
        for (int i = 0; i < 6; i++) begin
            en1 = VEC[i][23:20];
            cyc(30);
            d1_sda = VEC[i][19:15];
            d1_scl = VEC[i][14:10];
            cyc(30);
            chk($sformatf("R2,R3 vector %0d", i), {sda1, scl1}, {VEC[i][9:5], VEC[i][4:0]});
            d1_sda = '0;
            d1_scl = '0;
            cyc(40);
        end
        en1 = 4'hF;
        cyc(30);

        // R9 short glitch on port 1 SDA
        begin
            logic [4:0] seen = 5'h1F;
            d1_sda[1] = 1'b1;
            cyc(1);
            d1_sda[1] = 1'b0;
            for (int k = 0; k < 12; k++) begin
                cyc(1);
                seen = seen & sda1;
            end
            chk("R9 glitch not repeated", seen, 5'h1F);
        end

        // R5 / R4 hold window
        d1_sda[0] = 1'b1;
        cyc(20);
        chk("R4 held and any low while sourced", {xsh, xsa}, 2'b00);
        d1_sda[0] = 1'b0;
        cyc(3);
        chk("R5 port 2 still held after release", sda1[2], 1'b0);
        cyc(5);
        chk("R4 held up before any", {xsh, xsa, sda1[2]}, 3'b100);
        cyc(25);
        chk("R5 all released after hold", {sda1, xsa, xsh}, 7'h7F);
        cyc(20);

        // R6 ACK from port 3 toward port 0
        d1_sda[0] = 1'b1;
        cyc(20);
        d1_sda[3] = 1'b1;
        cyc(5);
        d1_sda[0] = 1'b0;
        cyc(40);
        chk("R6 ack repeated to port 0", sda1, 5'b00000);
        d1_sda[3] = 1'b0;
        cyc(40);
        chk("R6 ack released", sda1, 5'h1F);

        // R6 clock stretch from port 2
        d1_scl[0] = 1'b1;
        cyc(20);
        d1_scl[2] = 1'b1;
        cyc(5);
        d1_scl[0] = 1'b0;
        cyc(40);
        chk("R6 stretch repeated to port 0", scl1, 5'b00000);
        d1_scl[2] = 1'b0;
        cyc(40);
        chk("R6 stretch released", scl1, 5'h1F);

        // R8 enable change while busy
        d1_sda[0] = 1'b1;
        cyc(20);
        en1 = 4'b1110;
        cyc(10);
        chk("R8 pending enable not applied", sda1[1], 1'b0);
        d1_sda[0] = 1'b0;
        cyc(40);
        d1_sda[0] = 1'b1;
        cyc(20);
        chk("R8 enable applied at idle", sda1, 5'b00010);
        d1_sda[0] = 1'b0;
        cyc(40);
        en1 = 4'hF;
        cyc(20);
        d1_scl[1] = 1'b1;
        cyc(20);
        chk("R8 port 1 enabled again", scl1, 5'b00000);
        d1_scl[1] = 1'b0;
        cyc(40);

        // R7 chained hubs
        d1_scl[4] = 1'b1;
        cyc(25);
        chk("R7 hub2 follows hub1 scl", {scl2, xch}, 6'b000000);
        d1_scl[4] = 1'b0;
        cyc(40);
        chk("R7 both hubs released scl", {scl1, scl2, xca, xch}, 12'hFFF);
        d2_sda[2] = 1'b1;
        cyc(25);
        chk("R7 hub1 follows hub2 sda", sda1, 5'b00000);
        d2_sda[2] = 1'b0;
        cyc(40);
        chk("R7 both hubs released sda", {sda1, sda2, xsa, xsh}, 12'hFFF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule